// File: doc/BRIEF.md
# Single-Line Serial Slave Bit-Timing Engine

This block is the physical-timing layer of a slave on a single-wire, open-drain serial bus. It counts a one-microsecond tick. From the line level it recognises bus resets, answers each reset with a presence pulse, and turns master write slots into received bits. In read slots it pulls the line low to return a 0. It also reports a line held low for a very long time, which a power manager uses to put the device to sleep.

A pin selects standard or overdrive timing. Each speed has its own reset threshold, sample point, read-hold time and presence window. The pin is taken into account only when a low period turns out to be a reset, so the speed cannot change in the middle of a transaction. Byte assembly and command decoding belong to the layer above. That layer sees one strobe per decoded bit and one strobe per reset, and it provides the next bit to send.

Top module: `owire_bit_engine`

## Requirements
- R1: After reset release, and with the line idle high, the engine is at standard speed and `pull_low`, `rx_valid`, `bus_reset`, `sleep_req` and `pio_restore` are all 0.
- R2: At standard speed, a line-low period of 121 ticks or more (more than 120 µs) gives exactly one `bus_reset` pulse, 123 clocks after the line input falls when the tick is present every clock. A low period of 120 ticks or less gives none.
- R3: At overdrive the same rule applies with a threshold of 17 ticks (more than 16 µs). The threshold is chosen by the speed pin as sampled at the start of that low period.
- R4: After a reset, once the line has risen, the engine waits 30 ticks (3 at overdrive) and then drives `pull_low` for exactly 120 ticks (12 at overdrive). Reset detection is suspended while its own presence pulse is on the line.
- R5: In a write slot the line is sampled once, 30 ticks (3 at overdrive) after the falling edge. High gives `rx_bit` = 1 and low gives 0. A master low time below the sample point decodes as 1.
- R6: When `tx_en` = 1 and `tx_bit` = 0 at the falling edge of a slot, `pull_low` holds the line low from the third clock after the edge, so that the line stays low for at least 15 ticks (2 at overdrive) from the edge.
- R7: When `tx_en` = 0, or when `tx_bit` = 1, a slot never asserts `pull_low`.
- R8: The speed register changes only when a reset is detected. It then takes the pin value sampled at that reset's falling edge. A pin change between resets leaves slot timing unchanged.
- R9: A line-low period of SLEEP_TICKS ticks gives one `pio_restore` pulse whatever the value of `sleep_en`. At the same moment `sleep_req` rises, but only when `sleep_en` = 1. It stays high until the line returns high.
- R10: `pull_low` is asserted only during a presence pulse or during the hold window of a read-0 slot.
- R11: Each slot yields exactly one `rx_valid` pulse of one clock, however long the master holds the line low (below the reset threshold).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| line_in | input | 1 | Bus line level, asynchronous |
| od_pin | input | 1 | Speed select: 1 overdrive, 0 standard |
| tx_en | input | 1 | Next slot is a read slot driven by this slave |
| tx_bit | input | 1 | Bit to return in the next read slot |
| sleep_en | input | 1 | Permits a sleep request on a long low |
| pull_low | output | 1 | Open-drain pull-down enable |
| rx_valid | output | 1 | One-clock strobe: `rx_bit` holds a decoded bit |
| rx_bit | output | 1 | Last decoded write-slot bit |
| bus_reset | output | 1 | One-clock strobe on a detected bus reset |
| sleep_req | output | 1 | Sleep request, held while the line stays low |
| pio_restore | output | 1 | One-clock strobe on a long low, ungated |

## Verification
With the tick present on every clock, a line falling before posedge k=1 reaches the synchroniser output after posedge 2. The slot starts at posedge 3. `rx_valid` therefore rises at posedge SAMPLE+2, `bus_reset` at posedge LIMIT+2, `pio_restore` at posedge SLEEP_TICKS+2, and the read-0 pull-down covers posedges 3 to RDV+1. The presence pull begins DELAY+3 clocks after the line is released and lasts exactly the presence length. The bench stamps every strobe with a posedge counter, samples on the falling clock edge, and compares the stamps with these offsets. It sweeps master low times across every sample point and reset threshold at both speeds.

// File: rtl/owire_pkg.sv
package owire_pkg;

  typedef enum logic [2:0] {
    OW_IDLE  = 3'd0,
    OW_SLOT  = 3'd1,
    OW_HOLD  = 3'd2,
    OW_RLOW  = 3'd3,
    OW_PWAIT = 3'd4,
    OW_PDRV  = 3'd5,
    OW_PREL  = 3'd6
  } ow_state_e;

  function automatic int unsigned ow_max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        IDLE_LV = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= IDLE_LV;
          else        chain_q[g] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= IDLE_LV;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/owire_low_timer.sv
module owire_low_timer #(
  parameter int unsigned STD_RST_TICKS = 121,
  parameter int unsigned OD_RST_TICKS  = 17,
  parameter int unsigned SLEEP_TICKS   = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic line_s,
  input  logic line_fall,
  input  logic od_pin,
  input  logic hold_clr,
  input  logic sleep_en,
  output logic rst_hit,
  output logic pin_at_fall,
  output logic bus_reset,
  output logic sleep_req,
  output logic pio_restore
);

  localparam int unsigned TW = $clog2(SLEEP_TICKS + 1);
  localparam logic [TW-1:0] SLP_TOP  = TW'(SLEEP_TICKS);
  localparam logic [TW-1:0] SLP_LAST = TW'(SLEEP_TICKS - 1);
  localparam logic [TW-1:0] STD_LAST = TW'(STD_RST_TICKS - 1);
  localparam logic [TW-1:0] OD_LAST  = TW'(OD_RST_TICKS - 1);

  logic [TW-1:0] low_cnt_q, low_cnt_d;
  logic          pin_q, pin_d;
  logic          rst_pls_q, slp_pls_q, slp_req_q, slp_req_d;
  logic          counting, slp_hit;
  logic [TW-1:0] rst_last;

  assign counting = ~line_s & ~hold_clr;
  assign rst_last = pin_q ? OD_LAST : STD_LAST;
  assign rst_hit  = counting & us_tick & (low_cnt_q == rst_last);
  assign slp_hit  = counting & us_tick & (low_cnt_q == SLP_LAST);

  always_comb begin
    low_cnt_d = low_cnt_q;
    if (!counting)                            low_cnt_d = '0;
    else if (us_tick && low_cnt_q != SLP_TOP) low_cnt_d = low_cnt_q + 1'b1;

    pin_d = pin_q;
    if (line_fall) pin_d = od_pin;

    slp_req_d = slp_req_q;
    if (line_s)                  slp_req_d = 1'b0;
    else if (slp_hit && sleep_en) slp_req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      pin_q     <= 1'b0;
      rst_pls_q <= 1'b0;
      slp_pls_q <= 1'b0;
      slp_req_q <= 1'b0;
    end else begin
      low_cnt_q <= low_cnt_d;
      pin_q     <= pin_d;
      rst_pls_q <= rst_hit;
      slp_pls_q <= slp_hit;
      slp_req_q <= slp_req_d;
    end
  end

  assign pin_at_fall = pin_q;
  assign bus_reset   = rst_pls_q;
  assign pio_restore = slp_pls_q;
  assign sleep_req   = slp_req_q;

  // R2
  single_reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !bus_reset);

  // R9
  sleep_with_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_req) |-> (pio_restore && $past(sleep_en)));

endmodule

// File: rtl/owire_slot_fsm.sv
module owire_slot_fsm
  import owire_pkg::*;
#(
  parameter int unsigned STD_SAMPLE = 30,
  parameter int unsigned OD_SAMPLE  = 3,
  parameter int unsigned STD_RDV    = 15,
  parameter int unsigned OD_RDV     = 2,
  parameter int unsigned STD_PWAIT  = 30,
  parameter int unsigned OD_PWAIT   = 3,
  parameter int unsigned STD_PLEN   = 120,
  parameter int unsigned OD_PLEN    = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic line_s,
  input  logic line_fall,
  input  logic rst_hit,
  input  logic pin_at_fall,
  input  logic tx_en,
  input  logic tx_bit,
  output logic pull_low,
  output logic rx_valid,
  output logic rx_bit,
  output logic pres_active
);

  localparam int unsigned SPAN = ow_max2(ow_max2(STD_SAMPLE, STD_PLEN),
                                         ow_max2(STD_PWAIT, STD_RDV)) + 1;
  localparam int unsigned CW   = $clog2(SPAN + 1);

  ow_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          drv0_q, drv0_d;
  logic          spd_q, spd_d;
  logic          rxv_q, rxv_d, rxb_q, rxb_d;
  logic          pull_q, pull_d;
  logic [CW-1:0] smp_l, rdv_l, pwt_l, pln_l;

  assign smp_l = spd_q ? CW'(OD_SAMPLE) : CW'(STD_SAMPLE);
  assign rdv_l = spd_q ? CW'(OD_RDV)    : CW'(STD_RDV);
  assign pwt_l = spd_q ? CW'(OD_PWAIT)  : CW'(STD_PWAIT);
  assign pln_l = spd_q ? CW'(OD_PLEN)   : CW'(STD_PLEN);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    drv0_d = drv0_q;
    spd_d  = spd_q;
    rxv_d  = 1'b0;
    rxb_d  = rxb_q;
    if (rst_hit) begin
      st_d  = OW_RLOW;
      spd_d = pin_at_fall;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        OW_IDLE: if (line_fall) begin
          st_d   = OW_SLOT;
          cnt_d  = us_tick ? CW'(1) : '0;
          drv0_d = tx_en & ~tx_bit;
        end
        OW_SLOT: if (us_tick) begin
          if (cnt_q == smp_l - 1'b1) begin
            rxv_d = 1'b1;
            rxb_d = line_s;
            st_d  = OW_HOLD;
          end
          cnt_d = cnt_q + 1'b1;
        end
        OW_HOLD: if (line_s) st_d = OW_IDLE;
        OW_RLOW: if (line_s) begin
          st_d  = OW_PWAIT;
          cnt_d = '0;
        end
        OW_PWAIT: if (us_tick) begin
          if (cnt_q == pwt_l - 1'b1) begin
            st_d  = OW_PDRV;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        OW_PDRV: if (us_tick) begin
          if (cnt_q == pln_l - 1'b1) begin
            st_d  = OW_PREL;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        OW_PREL: if (line_s) st_d = OW_IDLE;
        default: st_d = OW_IDLE;
      endcase
    end
    pull_d = (st_d == OW_PDRV) | ((st_d == OW_SLOT) & drv0_d & (cnt_d < rdv_l));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= OW_IDLE;
      cnt_q  <= '0;
      drv0_q <= 1'b0;
      spd_q  <= 1'b0;
      rxv_q  <= 1'b0;
      rxb_q  <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      drv0_q <= drv0_d;
      spd_q  <= spd_d;
      rxv_q  <= rxv_d;
      rxb_q  <= rxb_d;
      pull_q <= pull_d;
    end
  end

  assign pull_low    = pull_q;
  assign rx_valid    = rxv_q;
  assign rx_bit      = rxb_q;
  assign pres_active = (st_q == OW_PDRV) | (st_q == OW_PREL);

  // R10
  pull_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> ((st_q == OW_PDRV) || (st_q == OW_SLOT && drv0_q)));

  // R11
  one_rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  speed_on_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spd_q) |-> $past(rst_hit));

  // R4
  presence_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pres_active) |-> ($past(st_q) == OW_PWAIT));

endmodule

// File: rtl/owire_bit_engine.sv
module owire_bit_engine #(
  parameter int unsigned STD_RST_TICKS = 121,
  parameter int unsigned OD_RST_TICKS  = 17,
  parameter int unsigned STD_SAMPLE    = 30,
  parameter int unsigned OD_SAMPLE     = 3,
  parameter int unsigned STD_RDV       = 15,
  parameter int unsigned OD_RDV        = 2,
  parameter int unsigned STD_PWAIT     = 30,
  parameter int unsigned OD_PWAIT      = 3,
  parameter int unsigned STD_PLEN      = 120,
  parameter int unsigned OD_PLEN       = 12,
  parameter int unsigned SLEEP_TICKS   = 2000000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic line_in,
  input  logic od_pin,
  input  logic tx_en,
  input  logic tx_bit,
  input  logic sleep_en,
  output logic pull_low,
  output logic rx_valid,
  output logic rx_bit,
  output logic bus_reset,
  output logic sleep_req,
  output logic pio_restore
);

  logic line_s, line_d_q, line_fall;
  logic rst_hit, pin_at_fall, pres_active;

  owire_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (line_in),
    .q_sync  (line_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_d_q <= 1'b1;
    else        line_d_q <= line_s;
  end

  assign line_fall = line_d_q & ~line_s;

  owire_low_timer #(
    .STD_RST_TICKS (STD_RST_TICKS),
    .OD_RST_TICKS  (OD_RST_TICKS),
    .SLEEP_TICKS   (SLEEP_TICKS)
  ) i_low_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .us_tick     (us_tick),
    .line_s      (line_s),
    .line_fall   (line_fall),
    .od_pin      (od_pin),
    .hold_clr    (pres_active),
    .sleep_en    (sleep_en),
    .rst_hit     (rst_hit),
    .pin_at_fall (pin_at_fall),
    .bus_reset   (bus_reset),
    .sleep_req   (sleep_req),
    .pio_restore (pio_restore)
  );

  owire_slot_fsm #(
    .STD_SAMPLE (STD_SAMPLE),
    .OD_SAMPLE  (OD_SAMPLE),
    .STD_RDV    (STD_RDV),
    .OD_RDV     (OD_RDV),
    .STD_PWAIT  (STD_PWAIT),
    .OD_PWAIT   (OD_PWAIT),
    .STD_PLEN   (STD_PLEN),
    .OD_PLEN    (OD_PLEN)
  ) i_slot_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .us_tick     (us_tick),
    .line_s      (line_s),
    .line_fall   (line_fall),
    .rst_hit     (rst_hit),
    .pin_at_fall (pin_at_fall),
    .tx_en       (tx_en),
    .tx_bit      (tx_bit),
    .pull_low    (pull_low),
    .rx_valid    (rx_valid),
    .rx_bit      (rx_bit),
    .pres_active (pres_active)
  );

  // R1
  quiet_when_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset || pio_restore) |-> !$past(line_s));

endmodule

// File: tb/test_owire_bit_engine.sv
`timescale 1ns/1ps
module test_owire_bit_engine;

  localparam int SLP = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b1;
  logic m_low = 1'b0;
  logic od_pin = 1'b0, tx_en = 1'b0, tx_bit = 1'b0, sleep_en = 1'b0;
  logic pull_low, rx_valid, rx_bit, bus_reset, sleep_req, pio_restore;
  logic line_in;

  assign line_in = ~(m_low | pull_low);

  always #4 clk = ~clk;

  owire_bit_engine #(.SLEEP_TICKS(SLP)) i_owire_bit_engine (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .line_in(line_in),
    .od_pin(od_pin), .tx_en(tx_en), .tx_bit(tx_bit), .sleep_en(sleep_en),
    .pull_low(pull_low), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .bus_reset(bus_reset), .sleep_req(sleep_req), .pio_restore(pio_restore)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  int n_rst, c_rst, n_rx, c_rx, n_pull, c_pull, n_pio, c_pio;
  logic v_rx, seen_slp;
  int t0, t_rel;
  bit done = 0;

  always @(negedge clk) begin
    if (bus_reset) begin n_rst++; c_rst = cyc; end
    if (rx_valid) begin n_rx++; c_rx = cyc; v_rx = rx_bit; end
    if (pull_low) begin if (n_pull == 0) c_pull = cyc; n_pull++; end
    if (pio_restore) begin n_pio++; c_pio = cyc; end
    if (sleep_req) seen_slp = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic slot(input int len, input int idle);
    @(negedge clk);
    n_rst = 0; n_rx = 0; n_pull = 0; n_pio = 0; seen_slp = 1'b0;
    c_rst = -1; c_rx = -1; c_pull = -1; c_pio = -1; v_rx = 1'bx;
    m_low = 1'b1;
    t0 = cyc;
    repeat (len) @(negedge clk);
    m_low = 1'b0;
    t_rel = cyc;
    repeat (idle) @(negedge clk);
    tx_en = 1'b0;
  endtask

  task automatic check_reset(input int len, input int lim, input int dly, input int plen,
                             input string tag);
    bit exp_rst = (len >= lim);
    chk(n_rst == int'(exp_rst), {tag, " reset count"}, n_rst, int'(exp_rst));
    if (exp_rst) begin
      chk(c_rst == t0 + lim + 2, {tag, " reset cycle"}, c_rst - t0, lim + 2);
      // R4 presence placement and length
      chk(c_pull == t_rel + 3 + dly, "R4 presence start", c_pull - t_rel, 3 + dly);
      chk(n_pull == plen, "R4 presence length", n_pull, plen);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 quiet after reset
    chk({pull_low, rx_valid, bus_reset, sleep_req, pio_restore} == 5'b0, "R1 idle outputs",
        {pull_low, rx_valid, bus_reset, sleep_req, pio_restore}, 0);
    repeat (5) @(negedge clk);

    // R2 standard reset threshold
    for (int l = 118; l <= 123; l++) begin
      slot(l, 320);
      check_reset(l, 121, 30, 120, "R2");
    end

    // R5 and R11 standard write slots
    for (int l = 1; l <= 45; l++) begin
      slot(l, 60);
      chk(n_rx == 1, "R11 one strobe std", n_rx, 1);
      chk(v_rx == (l < 30), "R5 std bit", v_rx, int'(l < 30));
      chk(c_rx == t0 + 32, "R5 std sample cycle", c_rx - t0, 32);
      chk(n_pull == 0, "R7 write slot no pull", n_pull, 0);
    end

    // R6 read-0 at standard speed
    tx_en = 1'b1; tx_bit = 1'b0;
    slot(3, 60);
    chk(n_pull == 14, "R6 std hold length", n_pull, 14);
    chk(c_pull == t0 + 3, "R6 std hold start", c_pull - t0, 3);
    chk(n_rx == 1 && v_rx == 1'b1, "R6 line released by sample", v_rx, 1);

    // R7 no drive when bit is 1 or slave not sending
    tx_en = 1'b1; tx_bit = 1'b1;
    slot(3, 60);
    chk(n_pull == 0, "R7 tx bit one", n_pull, 0);
    tx_en = 1'b0; tx_bit = 1'b0;
    slot(3, 60);
    chk(n_pull == 0, "R7 tx disabled", n_pull, 0);

    // R8 pin change mid-transaction is ignored
    od_pin = 1'b1;
    slot(5, 60);
    chk(c_rx == t0 + 32 && v_rx == 1'b1, "R8 still standard", c_rx - t0, 32);

    // R3 reset with pin high switches to overdrive
    slot(150, 60);
    chk(n_rst == 1 && c_rst == t0 + 19, "R3 od threshold from pin", c_rst - t0, 19);
    chk(c_pull == t_rel + 6, "R4 od presence start", c_pull - t_rel, 6);
    chk(n_pull == 12, "R4 od presence length", n_pull, 12);

    // R8 pin low now, speed held at overdrive
    od_pin = 1'b0;
    slot(2, 30);
    chk(c_rx == t0 + 5 && v_rx == 1'b1, "R8 still overdrive", c_rx - t0, 5);
    od_pin = 1'b1;

    // R3 overdrive reset threshold
    for (int l = 15; l <= 18; l++) begin
      slot(l, 60);
      check_reset(l, 17, 3, 12, "R3");
    end

    // R5 overdrive write slots
    for (int l = 1; l <= 14; l++) begin
      slot(l, 30);
      chk(n_rx == 1, "R11 one strobe od", n_rx, 1);
      chk(v_rx == (l < 3), "R5 od bit", v_rx, int'(l < 3));
      chk(c_rx == t0 + 5, "R5 od sample cycle", c_rx - t0, 5);
    end

    // R6 read-0 at overdrive
    tx_en = 1'b1; tx_bit = 1'b0;
    slot(3, 30);
    chk(n_pull == 1 && c_pull == t0 + 3, "R6 od hold", n_pull, 1);

    // R9 long low with sleep enabled, then disabled
    sleep_en = 1'b1;
    slot(SLP + 20, 80);
    chk(n_pio == 1 && c_pio == t0 + SLP + 2, "R9 restore strobe", c_pio - t0, SLP + 2);
    chk(seen_slp == 1'b1, "R9 sleep raised", seen_slp, 1);
    chk(sleep_req == 1'b0, "R9 sleep cleared on high", sleep_req, 0);
    sleep_en = 1'b0;
    slot(SLP + 20, 80);
    chk(n_pio == 1, "R9 restore ungated", n_pio, 1);
    chk(seen_slp == 1'b0, "R9 sleep gated off", seen_slp, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule